// File: doc/BRIEF.md
# Multichannel DAC Register Controller

This block sits between a host register bus and a four-channel 16-bit serial DAC. The host first stores a conversion word in a data register. It then writes a channel-select byte, which starts a serial transfer of that word into the input latch of the chosen channel. An auto-load bit in the same byte decides what happens after the transfer. When it is clear, the new word only waits in the latch. When it is set, every channel output is updated together as soon as the last bit has been sent. A separate load command updates all four outputs at once, using whatever each latch holds.

While a transfer is in flight the block reports busy. A channel-select or load write that arrives during that time is dropped and sets a sticky error flag. Any write to the status register clears that flag. The status register also shows the output-range strap, so software knows which number coding the DAC expects. The data register may be refilled while a transfer is in flight, which lets the host prepare the next word early.

Top module: `dacreg_ctrl`

## Requirements
- R1: After a synchronous reset, the data register reads 0x0000, the channel-select register reads 0x0000, the status register reads 0 apart from the range bit, every chip select is high (inactive), the serial clock is low and the load strobe is low.
- R2: A write at offset 4 stores all 16 bits of the data register. The value reads back at offset 4 and is kept until the next write at offset 4; writes to other offsets leave it unchanged.
- R3: A channel-select write at offset 1, made while idle, drives low only the chip select given by bits 1:0 (0 selects cs bit 0, up to 3 selecting cs bit 3). It then sends the data register as 16 bits, most significant bit first, with `dac_sdata` stable at each rising edge of `dac_sclk`. The serial clock spends CLK_DIV cycles low and CLK_DIV cycles high for each bit, and it toggles only while a chip select is low.
- R4: With bit 7 of the channel-select byte at 0, the transfer raises no load strobe and the channel outputs keep their values; busy falls after the last bit.
- R5: With bit 7 at 1, one single-cycle load strobe follows the last bit and updates all four outputs from their latches together; busy stays high until that strobe is issued.
- R6: A load write at offset 7, made while idle, gives a single-cycle load strobe with no serial activity.
- R7: A channel-select or load write made while busy is ignored: it starts no transfer, gives no strobe and leaves the channel-select readback unchanged. It also sets the error flag, which is status bit 2.
- R8: The error flag stays set until a write at offset 3 (status), whatever the written data; that write clears it.
- R9: Status at offset 3 reads busy in bit 0 and the range strap in bit 1 (0 means bipolar range with two's complement coding, 1 means unipolar range with straight binary coding). Bits 7:3 read 0.
- R10: The channel-select register reads back bit 7 (auto-load) and bits 1:0 of the last accepted write. Bits 6:2 always read 0, even when they were written as 1.
- R11: A data register write while busy is accepted without raising the error flag and does not disturb the word being shifted out.
- R12: Read data is registered: `bus_rdata` shows the register addressed by `bus_addr` one clock later, and offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_wdata | input | DATA_W | Write data; byte registers use bits 7:0 |
| bus_rdata | output | DATA_W | Registered read data |
| range_strap | input | 1 | Output range strap, synchronized inside the block |
| dac_sclk | output | 1 | Serial clock toward the converters |
| dac_sdata | output | 1 | Serial data, MSB first |
| dac_cs_n | output | NUM_CH | Active-low chip select, one per channel |
| dac_ldac | output | 1 | Single-cycle strobe that updates all outputs together |

## Verification
If the shift register holds the wrong value, the latched word in the bench's DAC model shows it as soon as the chip select rises, 32*CLK_DIV cycles after the command. If the busy state or the FSM state is wrong, it shows up on the next write. A transfer that overlaps another one, a missing or extra load strobe, or an error flag that does not appear are all visible within one cycle of that write, both on the serial pins and in the status readback. A sticky flag that decays on its own, or one that survives a status write, shows up on the next status read.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  // Register offsets; software depends on these positions.
  localparam int OFS_CHSEL = 1;
  localparam int OFS_STAT  = 3;
  localparam int OFS_DATA  = 4;
  localparam int OFS_LOAD  = 7;

  // Bit positions inside the byte-wide registers.
  localparam int AUTOLOAD_BIT = 7;
  localparam int STAT_BUSY    = 0;
  localparam int STAT_RANGE   = 1;
  localparam int STAT_ERR     = 2;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LOW,
    SH_HIGH,
    SH_LOAD
  } sh_state_t;
endpackage

// File: rtl/dacreg_tick.sv
module dacreg_tick #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/dacreg_regs.sv
module dacreg_regs
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              range_strap,
  input  logic              busy,
  output logic              xfer_start,
  output logic [$clog2(NUM_CH)-1:0] xfer_chan,
  output logic              xfer_al,
  output logic [DATA_W-1:0] xfer_data,
  output logic              load_req,
  output logic              err_flag
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [DATA_W-1:0] data_q;
  logic [CH_W-1:0]   chan_q;
  logic              al_q;
  logic              err_q;
  logic [1:0]        range_sync_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  logic wr_chsel, wr_stat, wr_data, wr_load;

  assign wr_chsel = bus_we && (bus_addr == ADDR_W'(OFS_CHSEL));
  assign wr_stat  = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_data  = bus_we && (bus_addr == ADDR_W'(OFS_DATA));
  assign wr_load  = bus_we && (bus_addr == ADDR_W'(OFS_LOAD));

  // Commands go to the shifter in the write cycle, so busy is set at the same edge.
  assign xfer_start = wr_chsel && !busy;
  assign xfer_chan  = bus_wdata[CH_W-1:0];
  assign xfer_al    = bus_wdata[AUTOLOAD_BIT];
  assign xfer_data  = data_q;
  assign load_req   = wr_load && !busy;
  assign err_flag   = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q       <= '0;
      chan_q       <= '0;
      al_q         <= 1'b0;
      err_q        <= 1'b0;
      range_sync_q <= '0;
    end else begin
      range_sync_q <= {range_sync_q[0], range_strap};
      if (wr_data) begin
        data_q <= bus_wdata;
      end
      if (wr_chsel) begin
        if (busy) begin
          err_q <= 1'b1;
        end else begin
          chan_q <= bus_wdata[CH_W-1:0];
          al_q   <= bus_wdata[AUTOLOAD_BIT];
        end
      end
      if (wr_load && busy) begin
        err_q <= 1'b1;
      end
      if (wr_stat) begin
        err_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_CHSEL)) begin
      rd_mux[AUTOLOAD_BIT] = al_q;
      rd_mux[CH_W-1:0]     = chan_q;
    end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
      rd_mux[STAT_BUSY]  = busy;
      rd_mux[STAT_RANGE] = range_sync_q[1];
      rd_mux[STAT_ERR]   = err_q;
    end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
      rd_mux = data_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/dacreg_shifter.sv
module dacreg_shifter
  import dacreg_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_CH  = 4,
  parameter int CLK_DIV = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [$clog2(NUM_CH)-1:0] chan,
  input  logic                      autoload,
  input  logic [DATA_W-1:0]         data,
  input  logic                      load_req,
  output logic                      busy,
  output logic                      sclk,
  output logic                      sdata,
  output logic [NUM_CH-1:0]         cs_n,
  output logic                      ldac
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  sh_state_t         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic              al_q;
  logic              sclk_q;
  logic              busy_q;
  logic              ldac_q;
  logic              tick;
  logic              accept;
  logic              done;

  assign accept = start && (state_q == SH_IDLE);
  assign done   = (state_q == SH_HIGH) && tick && (bit_q == LAST_BIT);

  dacreg_tick #(.CLK_DIV(CLK_DIV)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .en   ((state_q == SH_LOW) || (state_q == SH_HIGH)),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SH_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      al_q    <= 1'b0;
      sclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      ldac_q  <= 1'b0;
    end else begin
      ldac_q <= 1'b0;
      case (state_q)
        SH_IDLE: begin
          if (accept) begin
            sh_q    <= data;
            bit_q   <= '0;
            al_q    <= autoload;
            busy_q  <= 1'b1;
            state_q <= SH_LOW;
          end else if (load_req) begin
            ldac_q <= 1'b1;
          end
        end
        SH_LOW: begin
          if (tick) begin
            sclk_q  <= 1'b1;
            state_q <= SH_HIGH;
          end
        end
        SH_HIGH: begin
          if (tick) begin
            sclk_q <= 1'b0;
            if (bit_q == LAST_BIT) begin
              if (al_q) begin
                state_q <= SH_LOAD;
              end else begin
                busy_q  <= 1'b0;
                state_q <= SH_IDLE;
              end
            end else begin
              bit_q   <= bit_q + 1'b1;
              sh_q    <= {sh_q[DATA_W-2:0], 1'b0};
              state_q <= SH_LOW;
            end
          end
        end
        SH_LOAD: begin
          ldac_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= SH_IDLE;
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  // One chip-select flop per channel.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cs
    logic cs_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cs_q <= 1'b1;
      end else if (accept && (chan == $clog2(NUM_CH)'(g))) begin
        cs_q <= 1'b0;
      end else if (done) begin
        cs_q <= 1'b1;
      end
    end
    assign cs_n[g] = cs_q;
  end

  assign busy  = busy_q;
  assign sclk  = sclk_q;
  assign sdata = sh_q[DATA_W-1];
  assign ldac  = ldac_q;
endmodule

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl #(
  parameter int DATA_W  = 16,
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 3,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              range_strap,
  output logic              dac_sclk,
  output logic              dac_sdata,
  output logic [NUM_CH-1:0] dac_cs_n,
  output logic              dac_ldac
);
  localparam int CH_W = $clog2(NUM_CH);

  logic              busy_w;
  logic              err_w;
  logic              start_w;
  logic [CH_W-1:0]   chan_w;
  logic              al_w;
  logic [DATA_W-1:0] data_w;
  logic              load_w;

  dacreg_regs #(
    .DATA_W (DATA_W),
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) regs_i (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .range_strap (range_strap),
    .busy        (busy_w),
    .xfer_start  (start_w),
    .xfer_chan   (chan_w),
    .xfer_al     (al_w),
    .xfer_data   (data_w),
    .load_req    (load_w),
    .err_flag    (err_w)
  );

  dacreg_shifter #(
    .DATA_W  (DATA_W),
    .NUM_CH  (NUM_CH),
    .CLK_DIV (CLK_DIV)
  ) shift_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start_w),
    .chan     (chan_w),
    .autoload (al_w),
    .data     (data_w),
    .load_req (load_w),
    .busy     (busy_w),
    .sclk     (dac_sclk),
    .sdata    (dac_sdata),
    .cs_n     (dac_cs_n),
    .ldac     (dac_ldac)
  );
endmodule

// File: rtl/dacreg_chk.sv
module dacreg_chk
  import dacreg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              busy,
  input logic              err_flag,
  input logic              dac_sclk,
  input logic [NUM_CH-1:0] dac_cs_n,
  input logic              dac_ldac
);
  logic cmd_wr, stat_wr;
  assign cmd_wr  = bus_we && ((bus_addr == ADDR_W'(OFS_CHSEL)) || (bus_addr == ADDR_W'(OFS_LOAD)));
  assign stat_wr = bus_we && (bus_addr == ADDR_W'(OFS_STAT));

  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dac_cs_n));

  // R3
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    dac_sclk |-> (dac_cs_n != {NUM_CH{1'b1}}));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ((dac_cs_n == {NUM_CH{1'b1}}) && !dac_sclk));

  // R5
  ldac_single_chk: assert property (@(posedge clk) disable iff (rst)
    dac_ldac |=> !dac_ldac);

  // R7
  busy_err_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy) |=> err_flag);

  // R7
  busy_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy) |=> !dac_ldac);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> !err_flag);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !stat_wr) |=> err_flag);
endmodule

bind dacreg_ctrl dacreg_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .busy     (busy_w),
  .err_flag (err_w),
  .dac_sclk (dac_sclk),
  .dac_cs_n (dac_cs_n),
  .dac_ldac (dac_ldac)
);

// File: tb/dacreg_ctrl_tb_top.sv
`timescale 1ns/1ps
module dacreg_ctrl_tb_top;
  localparam int DATA_W  = 16;
  localparam int NUM_CH  = 4;
  localparam int ADDR_W  = 3;
  localparam int CLK_DIV = 2;
  localparam logic [2:0] A_CHSEL = 3'd1, A_STAT = 3'd3, A_DATA = 3'd4, A_LOAD = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic range_strap = 1'b1;
  logic dac_sclk, dac_sdata, dac_ldac;
  logic [NUM_CH-1:0] dac_cs_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dacreg_ctrl #(
    .DATA_W (DATA_W), .NUM_CH (NUM_CH), .ADDR_W (ADDR_W), .CLK_DIV (CLK_DIV)
  ) dut_i (
    .clk (clk), .rst (rst), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .range_strap (range_strap),
    .dac_sclk (dac_sclk), .dac_sdata (dac_sdata), .dac_cs_n (dac_cs_n),
    .dac_ldac (dac_ldac)
  );

  // Bench model of the converters: input latches and output registers.
  logic [NUM_CH-1:0] prev_cs = '1;
  logic prev_sclk = 1'b0;
  logic [DATA_W-1:0] cap = '0;
  logic [DATA_W-1:0] lat  [NUM_CH] = '{default: '0};
  logic [DATA_W-1:0] outv [NUM_CH] = '{default: '0};
  logic [NUM_CH-1:0] cur_mask = '0;
  int xbits = 0;
  int nbits_total = 0;
  int xfer_cnt = 0;
  int ldac_cnt = 0;
  int ldac_run = 0;
  int ldac_maxw = 0;

  always @(negedge clk) begin
    prev_cs   <= dac_cs_n;
    prev_sclk <= dac_sclk;
    if (!rst) begin
      if (prev_cs == '1 && dac_cs_n != '1) begin
        xfer_cnt <= xfer_cnt + 1;
        cur_mask <= ~dac_cs_n;
        xbits    <= 0;
      end else begin
        cur_mask <= cur_mask | ~dac_cs_n;
      end
      if (dac_sclk && !prev_sclk) begin
        cap         <= {cap[DATA_W-2:0], dac_sdata};
        xbits       <= xbits + 1;
        nbits_total <= nbits_total + 1;
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (!prev_cs[i] && dac_cs_n[i]) lat[i] <= cap;
      end
      if (dac_ldac) begin
        for (int i = 0; i < NUM_CH; i++) outv[i] <= lat[i];
        ldac_cnt <= ldac_cnt + 1;
        ldac_run <= ldac_run + 1;
        if (ldac_run + 1 > ldac_maxw) ldac_maxw <= ldac_run + 1;
      end else begin
        ldac_run <= 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Tasks are entered at a falling edge and leave at a falling edge.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(A_STAT, s);
      if (!s[0]) return;
    end
    chk("wait_idle busy stuck", 1, 0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(A_DATA, v);  chk("R1 data reset", v, 16'h0000);
    rd(A_CHSEL, v); chk("R1 chsel reset", v, 16'h0000);
    rd(A_STAT, v);  chk("R1 R9 status reset", v, 16'h0002);
    chk("R1 cs_n idle", dac_cs_n, 4'hF);
    chk("R1 sclk low", dac_sclk, 0);
    chk("R1 ldac low", dac_ldac, 0);
    rd(3'd2, v);    chk("R12 unmapped reads 0", v, 16'h0000);
  endtask

  task automatic t_data();
    logic [15:0] v;
    wr(A_DATA, 16'hA5C3); rd(A_DATA, v); chk("R2 data readback", v, 16'hA5C3);
    wr(A_DATA, 16'h3C5A); rd(A_DATA, v); chk("R2 data rewrite", v, 16'h3C5A);
    wr(A_STAT, 16'hFFFF); wr(3'd2, 16'h1111);
    rd(A_DATA, v); chk("R2 data kept", v, 16'h3C5A);
  endtask

  task automatic t_plain();
    logic [15:0] v;
    int lc = ldac_cnt, xc = xfer_cnt;
    wr(A_DATA, 16'h8001);
    wr(A_CHSEL, 16'h0002);
    rd(A_STAT, v); chk("R9 busy bit set", v, 16'h0003);
    wait_idle();
    chk("R3 one transfer", xfer_cnt, xc + 1);
    chk("R3 only ch2 selected", cur_mask, 4'b0100);
    chk("R3 16 bits", xbits, 16);
    chk("R3 latch MSB first", lat[2], 16'h8001);
    chk("R4 no strobe", ldac_cnt, lc);
    chk("R4 output unchanged", outv[2], 16'h0000);
  endtask

  task automatic t_autoload();
    int lc = ldac_cnt;
    wr(A_DATA, 16'h1234);
    wr(A_CHSEL, 16'h0080);
    wait_idle();
    chk("R5 ch0 latch", lat[0], 16'h1234);
    chk("R5 one strobe", ldac_cnt, lc + 1);
    chk("R5 strobe width", ldac_maxw, 1);
    chk("R5 ch0 output", outv[0], 16'h1234);
    chk("R5 ch2 output updated together", outv[2], 16'h8001);
  endtask

  task automatic t_load();
    int lc, nb, xc;
    wr(A_DATA, 16'h5555);
    wr(A_CHSEL, 16'h0003);
    wait_idle();
    chk("R4 ch3 output held", outv[3], 16'h0000);
    lc = ldac_cnt; nb = nbits_total; xc = xfer_cnt;
    wr(A_LOAD, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R6 one strobe", ldac_cnt, lc + 1);
    chk("R6 ch3 output", outv[3], 16'h5555);
    chk("R6 ch0 output", outv[0], 16'h1234);
    chk("R6 no serial bits", nbits_total, nb);
    chk("R6 no transfer", xfer_cnt, xc);
    chk("R6 strobe width", ldac_maxw, 1);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    int lc = ldac_cnt, xc = xfer_cnt;
    wr(A_DATA, 16'h0BAD);
    wr(A_CHSEL, 16'h0001);
    wr(A_CHSEL, 16'h0083);
    wr(A_LOAD, 16'h0000);
    rd(A_STAT, v); chk("R7 error set while busy", v, 16'h0007);
    wait_idle();
    rd(A_CHSEL, v); chk("R7 chsel unchanged", v, 16'h0001);
    chk("R7 single transfer", xfer_cnt, xc + 1);
    chk("R7 only ch1 selected", cur_mask, 4'b0010);
    chk("R7 no strobe", ldac_cnt, lc);
    chk("R7 ch1 latch", lat[1], 16'h0BAD);
    chk("R7 ch1 output held", outv[1], 16'h0000);
    rd(A_STAT, v); chk("R8 error sticky", v, 16'h0006);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, v); chk("R8 error cleared", v, 16'h0002);
  endtask

  task automatic t_data_busy();
    logic [15:0] v;
    wr(A_DATA, 16'h0F0F);
    wr(A_CHSEL, 16'h0000);
    wr(A_DATA, 16'hF0F0);
    wait_idle();
    chk("R11 shifted word intact", lat[0], 16'h0F0F);
    rd(A_DATA, v); chk("R11 new data kept", v, 16'hF0F0);
    rd(A_STAT, v); chk("R11 no error", v, 16'h0002);
  endtask

  task automatic t_chsel_rb();
    logic [15:0] v;
    wr(A_CHSEL, 16'h00FE);
    rd(A_CHSEL, v); chk("R10 readback masks 6:2", v, 16'h0082);
    wait_idle();
    chk("R10 ch2 latch", lat[2], 16'hF0F0);
    chk("R10 ch2 output autoloaded", outv[2], 16'hF0F0);
  endtask

  task automatic t_range();
    logic [15:0] v;
    range_strap = 1'b0;
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R9 range bipolar", v, 16'h0000);
    range_strap = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R9 range unipolar", v, 16'h0002);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_data();
    t_plain();
    t_autoload();
    t_load();
    t_busy();
    t_data_busy();
    t_chsel_rb();
    t_range();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule